// File: doc/BRIEF.md
# Float-to-Fixed FFT Input Prescaler

This block sits in front of an FFT core. It accepts one 32-bit single-precision float per clock, qualified by a valid strobe. The samples are expected to lie within plus or minus 16. The block divides each sample by a power of two, sixteen by default, by lowering the 8-bit exponent field. It leaves the sign and mantissa untouched and passes zero-exponent encodings through unchanged. The scaled value is then converted to a signed fixed-point word in Q1.(W-1) format, truncating toward zero.

The result is presented as a complex pair: the real part is the converted word and the imaginary part is all zeros. An output enable accompanies the pair one clock after the input strobe. Scaling and conversion are combinational, so the only register stage is the output stage. Values at or beyond the representable range are saturated according to their sign.

Top module: `fft_in_prescale`

## Requirements
- R1: For a positive normal input with exponent field above the shift (4), `out_re` equals trunc(x / 16 · 2^(W-1)), where x is the input value.
- R2: An input whose exponent field (bits 30:23) is zero, whether signed zero or subnormal, yields `out_re` = 0.
- R3: An input with exponent field 1 to 4 underflows when scaled and yields `out_re` = 0.
- R4: Conversion truncates toward zero for both signs: 3·2^-12 gives +1 and −3·2^-12 gives −1 at W = 16.
- R5: A negative input (bit 31 set) yields the two's-complement negation of the magnitude code, so `out_re` is never positive.
- R6: +16.0 saturates to 2^(W-1)−1 and −16.0 gives −2^(W-1).
- R7: Inputs above 16 in magnitude, including infinities and NaNs (exponent 255), saturate to the positive maximum or negative minimum by sign bit.
- R8: `out_im` is zero in every cycle.
- R9: `out_en` equals `in_valid` delayed by exactly one clock.
- R10: While `in_valid` is low, `out_re` keeps its last value whatever `in_sample` carries.
- R11: An asserted `rst` clears `out_en` and `out_re` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_sample` in this cycle |
| in_sample | input | 32 | Single-precision float sample |
| out_en | output | 1 | Output pair valid, one clock after `in_valid` |
| out_re | output | DATA_W | Real part, signed Q1.(DATA_W-1) |
| out_im | output | DATA_W | Imaginary part, always zero |

## Verification
Every exponent from 0 to 140 is swept, together with 255. Each exponent is combined with five mantissas (zero, single LSB, half, all ones, alternating) and both signs. This separates the zero-pass, underflow, normal, truncation and saturation regions, and shows where each boundary falls. Two small values whose exact code ends in one half show that rounding is toward zero rather than to nearest or toward minus infinity. Idle cycles with a changing sample on the input separate holding the output from tracking it, and a reset asserted in mid-stream shows that the clear is asynchronous.

// File: rtl/fftpre_pkg.sv
`timescale 1ns/1ps
package fftpre_pkg;
   localparam int FP_W      = 32;
   localparam int FP_EXP_W  = 8;
   localparam int FP_MANT_W = 23;
   localparam int FP_BIAS   = 127;

   typedef struct packed {
      logic                 sign;
      logic [FP_EXP_W-1:0]  expo;
      logic [FP_MANT_W-1:0] frac;
   } sp_float_t;
endpackage

// File: rtl/fftpre_exp_scale.sv
`timescale 1ns/1ps
module fftpre_exp_scale
   import fftpre_pkg::*;
#(
   parameter int SHIFT = 4
) (
   input  sp_float_t din,
   output sp_float_t dout
);
   localparam logic [FP_EXP_W-1:0] SH = FP_EXP_W'(SHIFT);

   generate
      if (SHIFT == 0) begin : g_pass
         assign dout = din;
      end else begin : g_sub
         always_comb begin
            dout = din;
            if (din.expo > SH)
               dout.expo = din.expo - SH;
            else if (din.expo != '0)
               dout.expo = '0;   // underflow: becomes subnormal, sign/frac kept
         end
      end
   endgenerate
endmodule

// File: rtl/fftpre_to_fixed.sv
`timescale 1ns/1ps
module fftpre_to_fixed
   import fftpre_pkg::*;
#(
   parameter int W = 32
) (
   input  sp_float_t      din,
   output logic [W-1:0]   code
);
   localparam int SIG_W = FP_MANT_W + 1;
   localparam int PW    = SIG_W + W - 1;
   localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};
   localparam logic [FP_EXP_W-1:0] ONE_EXP = FP_EXP_W'(FP_BIAS);
   localparam logic [FP_EXP_W-1:0] RSH_BASE = FP_EXP_W'(FP_BIAS + FP_MANT_W);

   logic [PW-1:0]       sig_ext;
   logic [PW-1:0]       shifted;
   logic [FP_EXP_W-1:0] rsh;
   logic [W-1:0]        mag;

   always_comb begin
      sig_ext = PW'({1'b1, din.frac}) << (W - 1);
      rsh     = RSH_BASE - din.expo;
      shifted = sig_ext >> rsh;
      mag     = shifted[W-1:0];
      if (din.expo == '0)
         code = '0;
      else if (din.expo >= ONE_EXP)
         code = din.sign ? NEG_MIN : POS_MAX;
      else
         code = din.sign ? (~mag + W'(1)) : mag;
   end
endmodule

// File: rtl/fft_in_prescale.sv
`timescale 1ns/1ps
module fft_in_prescale
   import fftpre_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int SCALE_SHIFT = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [31:0]       in_sample,
   output logic              out_en,
   output logic [DATA_W-1:0] out_re,
   output logic [DATA_W-1:0] out_im
);
   localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [FP_EXP_W-1:0] SAT_EXP = FP_EXP_W'(FP_BIAS + SCALE_SHIFT);

   generate
      if (DATA_W < 2 || DATA_W > 64) begin : g_bad_width
         $error("fft_in_prescale: DATA_W must be 2..64");
      end
      if (SCALE_SHIFT < 0 || SCALE_SHIFT > 8) begin : g_bad_shift
         $error("fft_in_prescale: SCALE_SHIFT must be 0..8");
      end
   endgenerate

   sp_float_t            raw_f;
   sp_float_t            scaled_f;
   logic [DATA_W-1:0]    code;

   assign raw_f = sp_float_t'(in_sample);

   fftpre_exp_scale #(.SHIFT(SCALE_SHIFT)) u_scale (
      .din  (raw_f),
      .dout (scaled_f)
   );

   fftpre_to_fixed #(.W(DATA_W)) u_conv (
      .din  (scaled_f),
      .code (code)
   );

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         out_en <= 1'b0;
         out_re <= '0;
      end else begin
         out_en <= in_valid;
         if (in_valid)
            out_re <= code;
      end
   end

   assign out_im = '0;

   a_r9_en_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_en);
   a_r9_en_idle: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_en);
   a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_re));
   a_r2_zero_exp: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_sample[30:23] == 8'd0) |=> (out_re == '0));
   a_r6_pos_sat: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_sample[31] && in_sample[30:23] >= SAT_EXP) |=> (out_re == POS_MAX));
   a_r5_neg_sign: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_sample[31]) |=> (out_re[DATA_W-1] || out_re == '0));
endmodule

// File: tb/fft_in_prescale_test.sv
`timescale 1ns/1ps
module fft_in_prescale_test;
   localparam int TW = 16;

   logic          clk = 1'b0;
   logic          rst;
   logic          in_valid;
   logic [31:0]   in_sample;
   logic          out_en;
   logic [TW-1:0] out_re;
   logic [TW-1:0] out_im;

   int total  = 0;
   int failed = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   fft_in_prescale #(.DATA_W(TW), .SCALE_SHIFT(4)) uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .out_en(out_en), .out_re(out_re), .out_im(out_im)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint expv);
      total++;
      if (!ok) begin
         failed++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // expected Q1.(TW-1) code from the float value, divided by 16
   function automatic longint exp_code(input logic [31:0] b);
      int  e;
      real mag, p, lim;
      e   = int'(b[30:23]);
      lim = 2.0 ** (TW - 1);
      if (e == 255) return b[31] ? -$rtoi(lim) : $rtoi(lim) - 1;
      if (e == 0) mag = real'(b[22:0]) * (2.0 ** (-149));
      else        mag = (1.0 + real'(b[22:0]) / 8388608.0) * (2.0 ** (e - 127));
      p = mag / 16.0 * lim;
      if (!b[31]) return (p >= lim) ? $rtoi(lim) - 1 : longint'($rtoi(p));
      else        return (p >= lim) ? -$rtoi(lim) : -longint'($rtoi(p));
   endfunction

   function automatic string tag_of(input logic [31:0] b);
      int e = int'(b[30:23]);
      if (e == 131 && b[22:0] == 0) return "R6";
      if (e >= 131) return "R7";
      if (e == 0)   return "R2";
      if (e <= 4)   return "R3";
      if (b[31])    return "R5";
      return "R1";
   endfunction

   task automatic apply(input logic [31:0] b, input string tag);
      longint ex;
      @(negedge clk);
      in_valid  = 1'b1;
      in_sample = b;
      @(posedge clk);
      #1;
      ex = exp_code(b);
      check(out_re == ex[TW-1:0], tag, longint'($signed(out_re)), ex);
      check(out_en == 1'b1, "R9", longint'(out_en), 1);
      check(out_im == '0, "R8", longint'(out_im), 0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++;
         failed++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   end

   initial begin
      logic [22:0] mants [5];
      mants[0] = 23'h000000; mants[1] = 23'h000001; mants[2] = 23'h400000;
      mants[3] = 23'h7FFFFF; mants[4] = 23'h2AAAAA;
      rst = 1'b1; in_valid = 1'b0; in_sample = 32'h0;
      repeat (3) @(negedge clk);
      // R11: reset state
      check(out_en == 1'b0, "R11", longint'(out_en), 0);
      check(out_re == '0, "R11", longint'(out_re), 0);
      check(out_im == '0, "R8", longint'(out_im), 0);
      rst = 1'b0;

      // sweep exponents / mantissas / signs
      for (int e = 0; e <= 141; e++) begin
         for (int m = 0; m < 5; m++) begin
            for (int s = 0; s < 2; s++) begin
               logic [31:0] b;
               b = {s[0], (e == 141) ? 8'd255 : e[7:0], mants[m]};
               apply(b, tag_of(b));
            end
         end
      end

      // R6 exact bounds
      apply(32'h41800000, "R6");   // +16.0 -> 32767
      apply(32'hC1800000, "R6");   // -16.0 -> -32768
      // R4 truncation toward zero: +-3*2^-12 -> +-1.5 LSB -> +-1
      apply(32'h3A400000, "R4");
      check(out_re == 16'h0001, "R4", longint'($signed(out_re)), 1);
      apply(32'hBA400000, "R4");
      check(out_re == 16'hFFFF, "R4", longint'($signed(out_re)), -1);

      // R10 hold while idle, R9 enable drops
      apply(32'h40000000, "R1");   // 2.0 -> 4096
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         in_valid  = 1'b0;
         in_sample = 32'h3F000000 + 32'(k) * 32'h00100000;
         @(posedge clk);
         #1;
         check(out_re == 16'd4096, "R10", longint'($signed(out_re)), 4096);
         check(out_en == 1'b0, "R9", longint'(out_en), 0);
      end

      // R11 asynchronous clear mid-stream
      apply(32'h40400000, "R1");   // 3.0 -> 6144
      @(negedge clk);
      rst = 1'b1;
      #1;
      check(out_en == 1'b0, "R11", longint'(out_en), 0);
      check(out_re == '0, "R11", longint'(out_re), 0);
      @(negedge clk);
      rst = 1'b0;
      in_valid = 1'b0;
      apply(32'hBF800000, "R5");   // -1.0 -> -2048

      done = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end
endmodule